// File: doc/BRIEF.md
# Receive Frame-Sync Pin Function Selector

This block owns one shared pin of a serial audio port and decides what that pin does. The pin can be a general-purpose I/O bit, the receiver frame sync (as an input or an output), a serial flag (an output flag or an input flag), or the enable for an external transmit buffer. A small held configuration picks between GPIO and the serial function. When the serial function is chosen, three control bits pick the role: a synchronous-mode bit, a buffer-enable select bit and a direction bit.

The frame sync, the slot boundaries and the transmit activity come from the rest of the port as strobes. The block only routes them. In flag roles, values move only on a flag-update strobe. That strobe is the frame sync in normal mode and the slot boundary in network mode. The pin input always passes through a synchronizer before anything reads or captures it.

Top module: `fsync_pin_mux`

## Requirements
- R1: After reset the held configuration is disconnected, and `pin_oe`, `pin_out`, `gpio_rd` and `iflag_stat` are all 0.
- R2: A write on `cfg_we` stores `cfg_wdata` into the held configuration, effective from the next clock edge. The encoding is: 00 disconnected, 01 GPIO input, 10 GPIO output, 11 serial function. In GPIO output, `pin_oe` is 1 and `pin_out` follows `gpio_dout`. In GPIO input, `pin_oe` is 0 and `gpio_rd` shows the synchronized pin.
- R3: While disconnected, `pin_oe` is 0 and `gpio_rd` is 0, whatever the pin does.
- R4: The pin input passes through a two-flop synchronizer. A change on `pin_in` reaches `gpio_rd` after exactly two rising clock edges.
- R5: In the serial function with `sync_mode`=0 and `dir_sel`=1, the pin outputs the frame sync. `pin_oe` is 1, and both `pin_out` and `rx_fs_in` equal `rx_fs_out`.
- R6: In the serial function with `sync_mode`=0 and `dir_sel`=0, the frame sync is an input. `pin_oe` is 0 and `rx_fs_in` carries the synchronized pin.
- R7: In the serial function with `sync_mode`=1, `bufen_sel`=0 and `dir_sel`=1, the pin is the output flag. `pin_oe` is 1. `pin_out` shows a held flag that loads `oflag_bit` only at a clock edge where the flag-update strobe is high. Changes to `oflag_bit` at other times have no effect on the pin.
- R8: The flag-update strobe is `fs_strobe` when `net_mode`=0 and `slot_strobe` when `net_mode`=1. The unselected strobe has no effect on either flag.
- R9: In the serial function with `sync_mode`=1, `bufen_sel`=0 and `dir_sel`=0, the pin is the input flag and `pin_oe` is 0. `iflag_stat` loads the synchronized pin at a clock edge where the flag-update strobe is high, and holds its value at all other times.
- R10: In the serial function with `sync_mode`=1, `bufen_sel`=1 and `dir_sel`=1, the pin drives the external buffer enable. `pin_oe` is 1 and `pin_out` equals `tx_active` as it was one clock earlier.
- R11: In the serial function with `sync_mode`=1, `bufen_sel`=1 and `dir_sel`=0, the pin is idle: `pin_oe` is 0 and `pin_out` is 0.
- R12: Whenever `pin_oe` is 0, `pin_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the held pin configuration |
| cfg_wdata | input | 2 | New configuration: 00 off, 01 GPIO in, 10 GPIO out, 11 serial |
| gpio_dout | input | 1 | Value driven in GPIO output configuration |
| sync_mode | input | 1 | 0 selects frame-sync role, 1 selects flag/buffer roles |
| bufen_sel | input | 1 | In synchronous mode, 1 selects the buffer-enable role |
| dir_sel | input | 1 | Direction: 1 output, 0 input |
| net_mode | input | 1 | 1 selects slot strobe for flag updates, 0 the frame strobe |
| oflag_bit | input | 1 | Control-register output flag value |
| fs_strobe | input | 1 | Frame-sync boundary strobe |
| slot_strobe | input | 1 | Slot boundary strobe |
| rx_fs_out | input | 1 | Internally generated receive frame sync |
| tx_active | input | 1 | Transmitter is shifting an active slot |
| pin_in | input | 1 | Pad input value |
| pin_out | output | 1 | Pad output value |
| pin_oe | output | 1 | Pad output enable |
| rx_fs_in | output | 1 | Frame sync delivered to the receivers |
| iflag_stat | output | 1 | Captured input-flag status |
| gpio_rd | output | 1 | GPIO read value |

## Verification
The bound checker watches several rules on every cycle. The pad never drives a 1 while its enable is off. The disconnected state never drives and never reads. The input-flag status and the output-flag pin never change without an update strobe. The buffer enable always trails the transmit activity by one cycle. The directed scenarios are needed for the rest. They show the exact two-edge synchronizer delay, the configuration encoding and the strobe chosen by network mode. They also show that the captured flag values are the right ones, which the per-cycle rules cannot tell apart from stale values.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    // Held pin configuration, encoding visible on cfg_wdata
    typedef enum logic [1:0] {
        CFG_DISC   = 2'b00,
        CFG_GIN    = 2'b01,
        CFG_GOUT   = 2'b10,
        CFG_SERIAL = 2'b11
    } pin_cfg_e;

    // Resolved pin role
    typedef enum logic [2:0] {
        FN_OFF,
        FN_GPIO_IN,
        FN_GPIO_OUT,
        FN_FS_IN,
        FN_FS_OUT,
        FN_OFLAG,
        FN_IFLAG,
        FN_BUFEN
    } pin_fn_e;

    typedef struct packed {
        pin_cfg_e cfg;
    } cfg_state_t;

    typedef struct packed {
        logic oflag;
        logic iflag;
        logic bufen;
    } flag_state_t;

endpackage

// File: rtl/fsp_sync.sv
module fsp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[LAST];
endmodule

// File: rtl/fsp_cfg.sv
module fsp_cfg
    import fsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_wdata,
    output pin_cfg_e   cfg
);
    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) st_d.cfg = pin_cfg_e'(cfg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cfg: CFG_DISC};
        else        st_q <= st_d;
    end

    assign cfg = st_q.cfg;
endmodule

// File: rtl/fsp_decode.sv
module fsp_decode
    import fsp_pkg::*;
(
    input  pin_cfg_e cfg,
    input  logic     sync_mode,
    input  logic     bufen_sel,
    input  logic     dir_sel,
    output pin_fn_e  fn
);
    always_comb begin
        unique case (cfg)
            CFG_GIN:  fn = FN_GPIO_IN;
            CFG_GOUT: fn = FN_GPIO_OUT;
            CFG_SERIAL: begin
                if (!sync_mode)      fn = dir_sel ? FN_FS_OUT : FN_FS_IN;
                else if (!bufen_sel) fn = dir_sel ? FN_OFLAG  : FN_IFLAG;
                else                 fn = dir_sel ? FN_BUFEN  : FN_OFF;
            end
            default:  fn = FN_OFF;
        endcase
    end
endmodule

// File: rtl/fsp_flags.sv
module fsp_flags
    import fsp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  pin_fn_e fn,
    input  logic    net_mode,
    input  logic    fs_strobe,
    input  logic    slot_strobe,
    input  logic    oflag_bit,
    input  logic    pin_s,
    input  logic    tx_active,
    output logic    oflag_q,
    output logic    iflag_q,
    output logic    bufen_q
);
    flag_state_t st_d, st_q;
    logic        upd;

    always_comb begin
        upd   = net_mode ? slot_strobe : fs_strobe;
        st_d  = st_q;
        if (upd && fn == FN_OFLAG) st_d.oflag = oflag_bit;
        if (upd && fn == FN_IFLAG) st_d.iflag = pin_s;
        st_d.bufen = tx_active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oflag_q = st_q.oflag;
    assign iflag_q = st_q.iflag;
    assign bufen_q = st_q.bufen;
endmodule

// File: rtl/fsync_pin_mux.sv
module fsync_pin_mux
    import fsp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_wdata,
    input  logic       gpio_dout,
    input  logic       sync_mode,
    input  logic       bufen_sel,
    input  logic       dir_sel,
    input  logic       net_mode,
    input  logic       oflag_bit,
    input  logic       fs_strobe,
    input  logic       slot_strobe,
    input  logic       rx_fs_out,
    input  logic       tx_active,
    input  logic       pin_in,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       rx_fs_in,
    output logic       iflag_stat,
    output logic       gpio_rd
);
    pin_cfg_e cfg_q;
    pin_fn_e  fn;
    logic     pin_s;
    logic     oflag_q, iflag_q, bufen_q;

    fsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din (pin_in),
        .dout (pin_s)
    );

    fsp_cfg u_cfg (
        .clk (clk),
        .rst_n (rst_n),
        .cfg_we (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg (cfg_q)
    );

    fsp_decode u_dec (
        .cfg (cfg_q),
        .sync_mode (sync_mode),
        .bufen_sel (bufen_sel),
        .dir_sel (dir_sel),
        .fn (fn)
    );

    fsp_flags u_flags (
        .clk (clk),
        .rst_n (rst_n),
        .fn (fn),
        .net_mode (net_mode),
        .fs_strobe (fs_strobe),
        .slot_strobe (slot_strobe),
        .oflag_bit (oflag_bit),
        .pin_s (pin_s),
        .tx_active (tx_active),
        .oflag_q (oflag_q),
        .iflag_q (iflag_q),
        .bufen_q (bufen_q)
    );

    // Pad and read-side routing
    always_comb begin
        pin_out  = 1'b0;
        pin_oe   = 1'b0;
        rx_fs_in = 1'b0;
        gpio_rd  = 1'b0;
        unique case (fn)
            FN_GPIO_IN:  gpio_rd = pin_s;
            FN_GPIO_OUT: begin
                pin_oe  = 1'b1;
                pin_out = gpio_dout;
                gpio_rd = pin_s;
            end
            FN_FS_IN:    rx_fs_in = pin_s;
            FN_FS_OUT: begin
                pin_oe   = 1'b1;
                pin_out  = rx_fs_out;
                rx_fs_in = rx_fs_out;
            end
            FN_OFLAG: begin
                pin_oe  = 1'b1;
                pin_out = oflag_q;
            end
            FN_BUFEN: begin
                pin_oe  = 1'b1;
                pin_out = bufen_q;
            end
            default: ;
        endcase
    end

    assign iflag_stat = iflag_q;
endmodule

// File: rtl/fsync_pin_mux_chk.sv
module fsync_pin_mux_chk
    import fsp_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input pin_cfg_e cfg_state,
    input logic     sync_mode,
    input logic     bufen_sel,
    input logic     dir_sel,
    input logic     net_mode,
    input logic     fs_strobe,
    input logic     slot_strobe,
    input logic     rx_fs_out,
    input logic     tx_active,
    input logic     pin_out,
    input logic     pin_oe,
    input logic     rx_fs_in,
    input logic     iflag_stat,
    input logic     gpio_rd
);
    logic seen_q;
    logic upd, serial, is_oflag, is_iflag, is_buf, is_fsout;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assign upd      = net_mode ? slot_strobe : fs_strobe;
    assign serial   = (cfg_state == CFG_SERIAL);
    assign is_oflag = serial && sync_mode && !bufen_sel && dir_sel;
    assign is_iflag = serial && sync_mode && !bufen_sel && !dir_sel;
    assign is_buf   = serial && sync_mode && bufen_sel && dir_sel;
    assign is_fsout = serial && !sync_mode && dir_sel;

    assert_quiet_pad_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_out);

    assert_disc_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_state == CFG_DISC) |-> (!pin_oe && !gpio_rd));

    assert_iflag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !($past(upd) && $past(is_iflag))) |-> $stable(iflag_stat));

    assert_oflag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && is_oflag && $past(is_oflag) && !$past(upd)) |-> $stable(pin_out));

    assert_bufen_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && is_buf) |-> (pin_oe && pin_out == $past(tx_active)));

    assert_fs_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_fsout |-> (pin_oe && pin_out == rx_fs_out && rx_fs_in == rx_fs_out));
endmodule

bind fsync_pin_mux fsync_pin_mux_chk u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .cfg_state (cfg_q),
    .sync_mode (sync_mode),
    .bufen_sel (bufen_sel),
    .dir_sel (dir_sel),
    .net_mode (net_mode),
    .fs_strobe (fs_strobe),
    .slot_strobe (slot_strobe),
    .rx_fs_out (rx_fs_out),
    .tx_active (tx_active),
    .pin_out (pin_out),
    .pin_oe (pin_oe),
    .rx_fs_in (rx_fs_in),
    .iflag_stat (iflag_stat),
    .gpio_rd (gpio_rd)
);

// File: tb/sim_fsync_pin_mux.sv
module sim_fsync_pin_mux;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, gpio_dout = 0, sync_mode = 0, bufen_sel = 0, dir_sel = 0;
    logic net_mode = 0, oflag_bit = 0, fs_strobe = 0, slot_strobe = 0;
    logic rx_fs_out = 0, tx_active = 0, pin_in = 0;
    logic [1:0] cfg_wdata = 2'b00;
    logic pin_out, pin_oe, rx_fs_in, iflag_stat, gpio_rd;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsync_pin_mux u0 (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_wdata (cfg_wdata), .gpio_dout (gpio_dout),
        .sync_mode (sync_mode), .bufen_sel (bufen_sel), .dir_sel (dir_sel),
        .net_mode (net_mode), .oflag_bit (oflag_bit),
        .fs_strobe (fs_strobe), .slot_strobe (slot_strobe),
        .rx_fs_out (rx_fs_out), .tx_active (tx_active), .pin_in (pin_in),
        .pin_out (pin_out), .pin_oe (pin_oe), .rx_fs_in (rx_fs_in),
        .iflag_stat (iflag_stat), .gpio_rd (gpio_rd)
    );

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic write_cfg(input logic [1:0] v);
        @(negedge clk);
        cfg_we = 1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
        #1;
    endtask

    task automatic pulse_fs();
        @(negedge clk); fs_strobe = 1;
        @(negedge clk); fs_strobe = 0;
        #1;
    endtask

    task automatic pulse_slot();
        @(negedge clk); slot_strobe = 1;
        @(negedge clk); slot_strobe = 0;
        #1;
    endtask

    task automatic t_reset();
        check(pin_oe, 0, "R1 oe after reset");
        check(pin_out, 0, "R1 out after reset");
        check(gpio_rd, 0, "R1 gpio_rd after reset");
        check(iflag_stat, 0, "R1 iflag after reset");
    endtask

    task automatic t_disc();
        @(negedge clk); pin_in = 1; gpio_dout = 1;
        step(3);
        check(pin_oe, 0, "R3 disconnected oe");
        check(gpio_rd, 0, "R3 disconnected read");
        pin_in = 0;
        step(3);
    endtask

    task automatic t_gpio();
        write_cfg(2'b01);
        check(pin_oe, 0, "R2 gpio input oe");
        @(negedge clk); pin_in = 1;
        step(1);
        check(gpio_rd, 0, "R4 one edge not yet through");
        step(1);
        check(gpio_rd, 1, "R4 two edges through");
        write_cfg(2'b10);
        gpio_dout = 1; #1;
        check(pin_oe, 1, "R2 gpio output oe");
        check(pin_out, 1, "R2 gpio output value 1");
        gpio_dout = 0; #1;
        check(pin_out, 0, "R2 gpio output value 0");
        pin_in = 0;
        write_cfg(2'b11);
    endtask

    task automatic t_async();
        @(negedge clk); sync_mode = 0; dir_sel = 1; rx_fs_out = 1; #1;
        check(pin_oe, 1, "R5 fs out oe");
        check(pin_out, 1, "R5 fs out value");
        check(rx_fs_in, 1, "R5 fs to receivers");
        rx_fs_out = 0; #1;
        check(pin_out, 0, "R5 fs out follows 0");
        @(negedge clk); dir_sel = 0; pin_in = 1; #1;
        check(pin_oe, 0, "R6 fs in oe");
        check(pin_out, 0, "R12 fs in out low");
        step(2);
        check(rx_fs_in, 1, "R6 fs in from pin");
        pin_in = 0;
        step(2);
        check(rx_fs_in, 0, "R6 fs in from pin low");
    endtask

    task automatic t_oflag();
        @(negedge clk); sync_mode = 1; bufen_sel = 0; dir_sel = 1; net_mode = 0; oflag_bit = 1;
        step(2);
        check(pin_oe, 1, "R7 oflag oe");
        check(pin_out, 0, "R7 no update without strobe");
        pulse_fs();
        check(pin_out, 1, "R7 update at frame strobe");
        oflag_bit = 0;
        step(2);
        check(pin_out, 1, "R7 bit change ignored");
        net_mode = 1;
        pulse_fs();
        check(pin_out, 1, "R8 frame strobe ignored in network mode");
        pulse_slot();
        check(pin_out, 0, "R8 update at slot strobe");
        net_mode = 0; oflag_bit = 1;
        pulse_slot();
        check(pin_out, 0, "R8 slot strobe ignored in normal mode");
    endtask

    task automatic t_iflag();
        @(negedge clk); dir_sel = 0; net_mode = 0; pin_in = 1;
        step(3);
        check(pin_oe, 0, "R9 iflag oe");
        check(iflag_stat, 0, "R9 no capture without strobe");
        pulse_fs();
        check(iflag_stat, 1, "R9 capture at frame strobe");
        pin_in = 0;
        step(3);
        check(iflag_stat, 1, "R9 held after pin change");
        net_mode = 1;
        pulse_fs();
        check(iflag_stat, 1, "R8 frame strobe ignored for iflag in network mode");
        pulse_slot();
        check(iflag_stat, 0, "R8 capture at slot strobe");
    endtask

    task automatic t_bufen();
        @(negedge clk); net_mode = 0; bufen_sel = 1; dir_sel = 1; tx_active = 1; #1;
        check(pin_oe, 1, "R10 bufen oe");
        check(pin_out, 0, "R10 lag one cycle");
        step(1);
        check(pin_out, 1, "R10 asserted while active");
        tx_active = 0;
        step(1);
        check(pin_out, 0, "R10 deasserted");
        tx_active = 1;
        @(negedge clk); dir_sel = 0; #1;
        check(pin_oe, 0, "R11 idle oe");
        check(pin_out, 0, "R11 idle out");
        tx_active = 0;
    endtask

    task automatic t_back_disc();
        write_cfg(2'b00);
        @(negedge clk); pin_in = 1;
        step(3);
        check(pin_oe, 0, "R3 rewritten disconnected oe");
        check(gpio_rd, 0, "R3 rewritten disconnected read");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_disc();
        t_gpio();
        t_async();
        t_oflag();
        t_iflag();
        t_bufen();
        t_back_disc();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule